// File: doc/BRIEF.md
# Two-Window Oscillator Steering Loop

This block closes a digital frequency-steering loop around a voltage-controlled oscillator. It collects signed phase-error readings from a phase measurement counter and sums them over a window measured in one-second ticks. When the window closes, it divides the sum by the number of readings to get the average error. It then moves the code of a DAC, which sets the oscillator's control voltage, by an amount proportional to that average.

The window length adapts to how far the oscillator is from lock. While the average error is large, a short window gives quick pull-in. Once the error is small, a long window smooths out reference jitter. A hysteresis band between the two thresholds stops the loop from toggling between lengths. A lock flag reports a settled loop. A single-cycle load strobe tells the DAC driver that a new code is ready.

With the default scaling, one error count is about 500 ppb. One step of the 16-bit DAC is about 2.5 ppb, so the default gain is 200 DAC steps per count. The 10-count and 6-count thresholds correspond to roughly 5 ppm and 3 ppm.

Top module: `osc_steer_loop`

## Requirements
- R1: During and after reset the DAC code is mid-scale (0x8000 for 16 bits), the short window is selected (`short_window` = 1), `locked` is 0 and `dac_load` is 0.
- R2: A window closes on the SHORT_S-th tick in short mode or the LONG_S-th tick in long mode. A window that holds readings produces exactly one `dac_load`, within ACC_W+4 cycles of its closing tick, and no load appears at any other time.
- R3: The average is the window sum divided by the reading count, truncated toward zero. The new code is the old code plus average × KP.
- R4: The DAC code saturates at 0 and at 2^DAC_W−1 and never wraps.
- R5: At each close, an average magnitude above FAST_TH selects the short window and one below SLOW_TH selects the long window. A value in between keeps the current length.
- R6: `locked` rises after two consecutive long-mode windows with an average of zero (|sum| < count). Any other loaded window clears it.
- R7: A window with no readings produces no load and leaves the code, the window length and the lock state unchanged.
- R8: A reading presented in the same cycle as the closing tick counts in the window that is closing.
- R9: A long window holding two readings per second, each at the most negative error, is averaged without overflow.
- R10: `dac_load` lasts one cycle. `dac_code`, `short_window` and `locked` change only in the cycle in which `dac_load` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-cycle pulse, once per second |
| err_valid | input | 1 | Phase-error reading strobe |
| err_value | input | ERR_W | Signed phase error in counts (two's complement) |
| dac_code | output | DAC_W | Oscillator control DAC code |
| dac_load | output | 1 | One-cycle strobe: new code ready |
| short_window | output | 1 | 1 = short window in use, 0 = long |
| locked | output | 1 | Loop settled |

## Verification
A corrupted window sum or reading count shows up at the next load as a wrong code, within about twenty cycles of the closing tick. A broken tick counter shows as a load that comes early, late, or not at all. A wrong mode or lock streak may stay hidden until a later window: an incorrect window length only shows at the following close, and a lost streak only shows when the second quiet long window fails to raise `locked`. The bench therefore runs windows back to back and compares the code, the mode and the lock flag on every load. It also checks that nothing moves between loads.

// File: rtl/osc_loop_pkg.sv
package osc_loop_pkg;

    typedef enum logic {
        WIN_SHORT = 1'b0,
        WIN_LONG  = 1'b1
    } win_mode_e;

    typedef struct packed {
        win_mode_e  mode;
        logic [1:0] streak;
    } loop_state_t;

    localparam logic [1:0] STREAK_LOCK = 2'd2;

    function automatic logic [1:0] next_streak(input logic [1:0] cur, input logic quiet_long);
        if (!quiet_long)
            return 2'd0;
        return (cur == STREAK_LOCK) ? STREAK_LOCK : cur + 2'd1;
    endfunction

endpackage

// File: rtl/osc_win_accum.sv
module osc_win_accum #(
    parameter int ERR_W   = 10,
    parameter int RD_W    = 11,
    parameter int ACC_W   = 21,
    parameter int SHORT_S = 100,
    parameter int LONG_S  = 600
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    tick,
    input  logic                    rd_valid,
    input  logic [ERR_W-1:0]        rd_err,
    input  logic                    short_mode,
    output logic                    close_valid,
    output logic signed [ACC_W-1:0] close_sum,
    output logic [RD_W-1:0]         close_cnt
);
    localparam int TK_W = $clog2(LONG_S + 1);

    logic [TK_W-1:0]         tick_cnt;
    logic [TK_W-1:0]         win_last;
    logic signed [ACC_W-1:0] sum_q, sum_nx;
    logic [RD_W-1:0]         cnt_q, cnt_nx;
    logic                    closing;

    always_comb begin
        win_last = short_mode ? TK_W'(SHORT_S - 1) : TK_W'(LONG_S - 1);
        closing  = tick && (tick_cnt >= win_last);
        sum_nx   = sum_q;
        cnt_nx   = cnt_q;
        if (rd_valid) begin
            sum_nx = sum_q + {{(ACC_W-ERR_W){rd_err[ERR_W-1]}}, rd_err};
            cnt_nx = cnt_q + RD_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tick_cnt    <= '0;
            sum_q       <= '0;
            cnt_q       <= '0;
            close_valid <= 1'b0;
            close_sum   <= '0;
            close_cnt   <= '0;
        end else if (closing) begin
            close_valid <= 1'b1;
            close_sum   <= sum_nx;
            close_cnt   <= cnt_nx;
            tick_cnt    <= '0;
            sum_q       <= '0;
            cnt_q       <= '0;
        end else begin
            close_valid <= 1'b0;
            sum_q       <= sum_nx;
            cnt_q       <= cnt_nx;
            if (tick)
                tick_cnt <= tick_cnt + TK_W'(1);
        end
    end

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> (cnt_q != {RD_W{1'b1}}));

    assert_window_bound_R2: assert property (@(posedge clk) disable iff (rst)
        tick_cnt <= TK_W'(LONG_S - 1));

endmodule

// File: rtl/osc_avg_div.sv
module osc_avg_div #(
    parameter int ACC_W = 21,
    parameter int RD_W  = 11
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic signed [ACC_W-1:0] dividend,
    input  logic [RD_W-1:0]         divisor,
    output logic                    done,
    output logic signed [ACC_W-1:0] quotient
);
    localparam int ST_W = $clog2(ACC_W);

    logic            busy;
    logic [ST_W-1:0] step;
    logic [RD_W:0]   rem, rem_sh, rem_nx;
    logic [ACC_W-1:0] quo, quo_nx;
    logic [RD_W-1:0] dvs;
    logic            neg;
    logic            ge;

    always_comb begin
        rem_sh = {rem[RD_W-1:0], quo[ACC_W-1]};
        ge     = rem_sh >= {1'b0, dvs};
        rem_nx = ge ? rem_sh - {1'b0, dvs} : rem_sh;
        quo_nx = {quo[ACC_W-2:0], ge};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            done     <= 1'b0;
            step     <= '0;
            rem      <= '0;
            quo      <= '0;
            dvs      <= '0;
            neg      <= 1'b0;
            quotient <= '0;
        end else begin
            done <= 1'b0;
            if (start) begin
                busy <= 1'b1;
                step <= '0;
                rem  <= '0;
                quo  <= dividend[ACC_W-1] ? -dividend : dividend;
                dvs  <= divisor;
                neg  <= dividend[ACC_W-1];
            end else if (busy) begin
                rem  <= rem_nx;
                quo  <= quo_nx;
                step <= step + ST_W'(1);
                if (step == ST_W'(ACC_W - 1)) begin
                    busy     <= 1'b0;
                    done     <= 1'b1;
                    quotient <= neg ? -$signed(quo_nx) : $signed(quo_nx);
                end
            end
        end
    end

    assert_start_idle_R2: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy);

    assert_nonzero_divisor_R7: assert property (@(posedge clk) disable iff (rst)
        start |-> (divisor != '0));

endmodule

// File: rtl/osc_steer_ctrl.sv
module osc_steer_ctrl
    import osc_loop_pkg::*;
#(
    parameter int DAC_W   = 16,
    parameter int ACC_W   = 21,
    parameter int KP      = 200,
    parameter int FAST_TH = 10,
    parameter int SLOW_TH = 6
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    avg_valid,
    input  logic signed [ACC_W-1:0] avg,
    output logic [DAC_W-1:0]        dac_code,
    output logic                    dac_load,
    output logic                    short_mode,
    output logic                    locked
);
    localparam int PW = ACC_W + DAC_W + 34;
    localparam logic signed [PW-1:0] CODE_MAX = PW'((64'd1 << DAC_W) - 64'd1);
    localparam logic [DAC_W-1:0]     CODE_MID = DAC_W'(64'd1 << (DAC_W - 1));

    loop_state_t             st, st_nx;
    logic [ACC_W-1:0]        mag;
    logic signed [PW-1:0]    avg_w, code_w, target;
    logic [DAC_W-1:0]        code_nx;

    always_comb begin
        mag    = avg[ACC_W-1] ? ACC_W'(-avg) : ACC_W'(avg);
        avg_w  = {{(PW-ACC_W){avg[ACC_W-1]}}, avg};
        code_w = {{(PW-DAC_W){1'b0}}, dac_code};
        target = code_w + avg_w * PW'(KP);
        if (target < 0)
            code_nx = '0;
        else if (target > CODE_MAX)
            code_nx = CODE_MAX[DAC_W-1:0];
        else
            code_nx = target[DAC_W-1:0];

        st_nx = st;
        if (mag > ACC_W'(FAST_TH))
            st_nx.mode = WIN_SHORT;
        else if (mag < ACC_W'(SLOW_TH))
            st_nx.mode = WIN_LONG;
        st_nx.streak = next_streak(st.streak, (st.mode == WIN_LONG) && (mag == '0));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st.mode   <= WIN_SHORT;
            st.streak <= '0;
            dac_code  <= CODE_MID;
            dac_load  <= 1'b0;
        end else begin
            dac_load <= avg_valid;
            if (avg_valid) begin
                st       <= st_nx;
                dac_code <= code_nx;
            end
        end
    end

    assign short_mode = (st.mode == WIN_SHORT);
    assign locked     = (st.streak == STREAK_LOCK);

    assert_load_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        dac_load |=> !dac_load);

    assert_code_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !dac_load |-> ($stable(dac_code) && $stable(short_mode) && $stable(locked)));

    assert_lock_long_R6: assert property (@(posedge clk) disable iff (rst)
        locked |-> !short_mode);

    assert_big_error_fast_R5: assert property (@(posedge clk) disable iff (rst)
        (avg_valid && (mag > ACC_W'(FAST_TH))) |=> (short_mode && !locked));

endmodule

// File: rtl/osc_steer_loop.sv
module osc_steer_loop #(
    parameter int ERR_W   = 10,
    parameter int DAC_W   = 16,
    parameter int SHORT_S = 100,
    parameter int LONG_S  = 600,
    parameter int KP      = 200,
    parameter int FAST_TH = 10,
    parameter int SLOW_TH = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_1hz,
    input  logic             err_valid,
    input  logic [ERR_W-1:0] err_value,
    output logic [DAC_W-1:0] dac_code,
    output logic             dac_load,
    output logic             short_window,
    output logic             locked
);
    localparam int RD_W  = $clog2(2 * LONG_S + 1) + 1;
    localparam int ACC_W = ERR_W + RD_W;

    logic                    close_valid;
    logic signed [ACC_W-1:0] close_sum;
    logic [RD_W-1:0]         close_cnt;
    logic                    div_start;
    logic                    div_done;
    logic signed [ACC_W-1:0] div_q;

    osc_win_accum #(
        .ERR_W(ERR_W), .RD_W(RD_W), .ACC_W(ACC_W),
        .SHORT_S(SHORT_S), .LONG_S(LONG_S)
    ) u_accum (
        .clk(clk), .rst(rst), .tick(tick_1hz),
        .rd_valid(err_valid), .rd_err(err_value),
        .short_mode(short_window),
        .close_valid(close_valid), .close_sum(close_sum), .close_cnt(close_cnt)
    );

    assign div_start = close_valid && (close_cnt != '0);

    osc_avg_div #(.ACC_W(ACC_W), .RD_W(RD_W)) u_div (
        .clk(clk), .rst(rst), .start(div_start),
        .dividend(close_sum), .divisor(close_cnt),
        .done(div_done), .quotient(div_q)
    );

    osc_steer_ctrl #(
        .DAC_W(DAC_W), .ACC_W(ACC_W), .KP(KP),
        .FAST_TH(FAST_TH), .SLOW_TH(SLOW_TH)
    ) u_ctrl (
        .clk(clk), .rst(rst), .avg_valid(div_done), .avg(div_q),
        .dac_code(dac_code), .dac_load(dac_load),
        .short_mode(short_window), .locked(locked)
    );

endmodule

// File: tb/tb_osc_steer_loop.sv
module tb_osc_steer_loop;
    localparam int SH = 4;
    localparam int LG = 8;
    localparam int KPV = 200;
    localparam int CMAX = 65535;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst = 1'b1;
    logic       tick_1hz = 1'b0;
    logic       err_valid = 1'b0;
    logic [9:0] err_value = '0;
    logic [15:0] dac_code;
    logic       dac_load;
    logic       short_window;
    logic       locked;

    osc_steer_loop #(.SHORT_S(SH), .LONG_S(LG)) dut (
        .clk(clk), .rst(rst), .tick_1hz(tick_1hz),
        .err_valid(err_valid), .err_value(err_value),
        .dac_code(dac_code), .dac_load(dac_load),
        .short_window(short_window), .locked(locked)
    );

    typedef struct {
        int code;
        bit shrt;
        bit lk;
        string tag;
    } exp_t;
    exp_t q[$];

    int checks = 0;
    int fails  = 0;
    int m_code = 32768;
    bit m_short = 1'b1;
    int m_streak = 0;
    bit finished = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor: pops expected items as loads appear
    always @(negedge clk) begin
        if (!rst && dac_load) begin
            if (q.size() == 0) begin
                check(1'b0, "R2 unexpected load", 1, 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                check(int'(dac_code) == e.code, {e.tag, " code"}, int'(dac_code), e.code);
                check(short_window == e.shrt, {e.tag, " window mode"}, int'(short_window), int'(e.shrt));
                check(locked == e.lk, {e.tag, " lock"}, int'(locked), int'(e.lk));
            end
        end
    end

    // driver: one full window, model update pushed at the closing tick
    task automatic run_window(input int v0, input int v1, input int per,
                              input bit on_close, input int vc, input string tag);
        int len;
        int sum;
        int n;
        len = m_short ? SH : LG;
        sum = 0;
        n = 0;
        for (int k = 0; k < len; k++) begin
            for (int j = 0; j < per; j++) begin
                int v;
                v = ((j + k) % 2 == 1) ? v1 : v0;
                @(negedge clk);
                err_valid = 1'b1;
                err_value = 10'(v);
                sum += v;
                n++;
                @(negedge clk);
                err_valid = 1'b0;
            end
            repeat (8) @(negedge clk);
            tick_1hz = 1'b1;
            if (k == len - 1 && on_close) begin
                err_valid = 1'b1;
                err_value = 10'(vc);
                sum += vc;
                n++;
            end
            @(negedge clk);
            tick_1hz = 1'b0;
            err_valid = 1'b0;
        end
        if (n > 0) begin
            int avg;
            int mag;
            int tgt;
            exp_t e;
            avg = sum / n;
            mag = (avg < 0) ? -avg : avg;
            tgt = m_code + avg * KPV;
            if (tgt < 0) tgt = 0;
            if (tgt > CMAX) tgt = CMAX;
            m_code = tgt;
            if (!m_short && mag == 0)
                m_streak = (m_streak >= 2) ? 2 : m_streak + 1;
            else
                m_streak = 0;
            if (mag > 10) m_short = 1'b1;
            else if (mag < 6) m_short = 1'b0;
            e.code = m_code;
            e.shrt = m_short;
            e.lk = (m_streak == 2);
            e.tag = tag;
            q.push_back(e);
        end
        repeat (40) @(negedge clk);
        check(q.size() == 0, {tag, " R2 load arrived in time"}, q.size(), 0);
        check(int'(dac_code) == m_code, {tag, " R10 code held"}, int'(dac_code), m_code);
        check(short_window == m_short, {tag, " R10 mode held"}, int'(short_window), int'(m_short));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(int'(dac_code) == 32768, "R1 reset code", int'(dac_code), 32768);
        check(short_window == 1'b1, "R1 reset window", int'(short_window), 1);
        check(locked == 1'b0, "R1 reset lock", int'(locked), 0);
        check(dac_load == 1'b0, "R1 reset load", int'(dac_load), 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check(int'(dac_code) == 32768, "R1 code after release", int'(dac_code), 32768);

        run_window(20, 20, 1, 1'b0, 0, "R3 R5 large error stays short");
        run_window(8, 8, 1, 1'b0, 0, "R5 band keeps short");
        run_window(5, -2, 2, 1'b0, 0, "R3 truncation, R5 enter long");
        run_window(-7, -8, 1, 1'b0, 0, "R3 negative truncation toward zero");
        run_window(8, 8, 1, 1'b0, 0, "R5 band keeps long");
        run_window(0, 0, 0, 1'b0, 0, "R7 empty window");
        check(locked == 1'b0, "R7 lock unchanged", int'(locked), 0);
        run_window(0, 1, 1, 1'b0, 0, "R6 first quiet long window");
        run_window(0, 0, 1, 1'b0, 0, "R6 second quiet long window locks");
        check(locked == 1'b1, "R6 locked after two", int'(locked), 1);
        run_window(0, 0, 0, 1'b0, 0, "R7 empty window keeps lock");
        check(locked == 1'b1, "R7 lock kept", int'(locked), 1);
        run_window(0, 0, 1, 1'b1, 9, "R8 closing-tick reading counts, R6 clears");
        run_window(-511, -511, 2, 1'b0, 0, "R9 full-scale long window, R4 floor");
        run_window(511, 511, 1, 1'b0, 0, "R4 ceiling");
        run_window(0, 0, 1, 1'b0, 0, "R6 short window never locks");
        check(locked == 1'b0, "R6 not locked after short window", int'(locked), 0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            check(1'b0, "watchdog expired", 1, 0);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule